// File: doc/BRIEF.md
# Memory-Mapped Digital I/O Port

This block places an eight-pin general-purpose I/O port on a 16-bit address bus with a byte-wide data path. It decodes every bus address into one of two regions. The low region is a 512-byte peripheral window. Every address above that window belongs to ordinary memory, and for those addresses the block raises a memory chip-select.

Three byte registers sit inside the window:
- A pin-state register. It shows the pins through a two-stage synchronizer.
- A drive-value register. A read returns whatever was last written to it, so software can set, clear or toggle bits with read-modify-write sequences.
- A per-pin direction register. It decides which pins the port drives.

The bus is synchronous. Writes take effect on the clock edge at which the write enable is sampled high. Read data is combinational from the current address and read enable.

Top module: `gpio_port`

## Requirements
- R1: An address whose bits 15..9 are all zero is a window access. For such an address `mem_cs` is 0, and bits 8..0 select a byte in the range 0x000..0x1FF.
- R2: `mem_cs` is 1 whenever any of address bits 15..9 is 1. A write to such an address changes no port register, even when its low nine bits match a register offset.
- R3: After reset the direction register is 0x00 (all pins are inputs) and the drive-value register is 0x00. As a result `pin_oe` and `pin_out` are both 0x00.
- R4: A write to window offset 0x022 loads the direction register. From the next clock edge onward, `pin_oe[i]` equals direction bit i (1 = output, 0 = input), and a read of offset 0x022 returns the written value.
- R5: A read of window offset 0x020 returns the pin levels, with bit i = 1 when pin i is high. A change on `pin_in` becomes visible after two rising clock edges, and not after only one.
- R6: `pin_out[i]` equals drive-value bit i when pin i is an output, and is 0 when pin i is an input.
- R7: A read of window offset 0x021 returns the last value written there. A set (OR), clear (AND-NOT) or toggle (XOR) built as read-modify-write gives the arithmetically expected value, and the register holds its value between writes.
- R8: `bus_rdata` is 0x00 for a window offset other than 0x020..0x022, when `bus_re` is 0, and when `mem_cs` is 1.
- R9: A write to offset 0x020 has no effect. The pin-state read afterwards still shows the pins, and the other two registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable, sampled on the clock edge |
| bus_re | input | 1 | Read enable, qualifies `bus_rdata` |
| bus_rdata | output | 8 | Read data, combinational |
| mem_cs | output | 1 | Memory chip-select for addresses above the window |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Pin drive levels |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The assertions take for granted that `bus_we` is never 1 together with an unknown address or data value. They also assume that `pin_in` is a plain two-valued level, which the synchronizer may sample at any time. To stay within these assumptions, the stimulus changes every input only on the falling clock edge and always gives the address and data a defined value when it raises `bus_we`. The read and write enables are never raised in the same cycle, so each read observes the state left by earlier writes only.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int unsigned OFS_W = 9;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PINS = 2'd1,
    SEL_DRV  = 2'd2,
    SEL_DIR  = 2'd3
  } reg_sel_t;

  localparam logic [OFS_W-1:0] OFS_PINS = 9'h020;
  localparam logic [OFS_W-1:0] OFS_DRV  = 9'h021;
  localparam logic [OFS_W-1:0] OFS_DIR  = 9'h022;

  // Map a window offset onto the register it names.
  function automatic reg_sel_t pick_reg(input logic [OFS_W-1:0] ofs);
    case (ofs)
      OFS_PINS: pick_reg = SEL_PINS;
      OFS_DRV:  pick_reg = SEL_DRV;
      OFS_DIR:  pick_reg = SEL_DIR;
      default:  pick_reg = SEL_NONE;
    endcase
  endfunction

  // Pad drive: only pins configured as outputs carry the drive value.
  function automatic logic [7:0] pad_drive(input logic [7:0] drv, input logic [7:0] dir);
    pad_drive = drv & dir;
  endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WIN_W  = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              win_hit,
  output logic              mem_sel,
  output logic [WIN_W-1:0]  win_ofs
);
  localparam int unsigned HI_W = ADDR_W - WIN_W;

  logic [HI_W-1:0] hi_bits;

  assign hi_bits = addr[ADDR_W-1:WIN_W];
  assign win_ofs = addr[WIN_W-1:0];
  assign mem_sel = |hi_bits;
  assign win_hit = (hi_bits == '0);

  always_comb begin
    if (!$isunknown(addr))
      assert (win_hit != mem_sel); // R1
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_t          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] drv_q,
  output logic [DATA_W-1:0] dir_q
);
  logic wr_drv;
  logic wr_dir;
  logic wr_pins;

  assign wr_drv  = wr_en && (sel == SEL_DRV);
  assign wr_dir  = wr_en && (sel == SEL_DIR);
  assign wr_pins = wr_en && (sel == SEL_PINS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_drv) drv_q <= wdata;
      if (wr_dir) dir_q <= wdata;
    end
  end

  AST_DRV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drv |=> drv_q == $past(wdata)); // R7
  AST_DRV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_drv |=> $stable(drv_q)); // R7
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q)); // R4
  AST_PINS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pins |=> $stable(drv_q) && $stable(dir_q)); // R9
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mem_cs,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe
);
  logic              win_hit;
  logic [OFS_W-1:0]  win_ofs;
  reg_sel_t          sel;
  logic              port_wr;
  logic [DATA_W-1:0] pins_q;
  logic [DATA_W-1:0] drv_q;
  logic [DATA_W-1:0] dir_q;

  gpio_addr_dec #(.ADDR_W(ADDR_W), .WIN_W(OFS_W)) u_dec (
    .addr    (bus_addr),
    .win_hit (win_hit),
    .mem_sel (mem_cs),
    .win_ofs (win_ofs)
  );

  assign sel     = win_hit ? pick_reg(win_ofs) : SEL_NONE;
  assign port_wr = bus_we && win_hit;

  gpio_in_sync #(.WIDTH(DATA_W), .STAGES(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pins_q)
  );

  gpio_regs #(.DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (port_wr),
    .sel   (sel),
    .wdata (bus_wdata),
    .drv_q (drv_q),
    .dir_q (dir_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (sel)
        SEL_PINS: bus_rdata = pins_q;
        SEL_DRV:  bus_rdata = drv_q;
        SEL_DIR:  bus_rdata = dir_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = pad_drive(drv_q, dir_q);

  AST_MEM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && mem_cs) |=> $stable(pin_oe) && $stable(pin_out)); // R2
  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && win_ofs == OFS_DIR) |=> pin_oe == $past(bus_wdata)); // R4
  AST_NO_DRIVE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0); // R6
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_re || mem_cs) |-> bus_rdata == '0); // R8
endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [7:0]  bus_rdata;
  logic        mem_cs;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .mem_cs(mem_cs),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Vector: {op[1:0], addr[15:0], data[7:0], expect[7:0]}
  // op 0 = write data, 1 = read and compare with expect, 2 = compare mem_cs with expect[0]
  localparam int NV = 14;
  localparam logic [33:0] VEC [NV] = '{
    {2'd2, 16'h0000, 8'h00, 8'h00},  // R1 lowest window address
    {2'd2, 16'h01FF, 8'h00, 8'h00},  // R1 top of window
    {2'd2, 16'h0200, 8'h00, 8'h01},  // R2 first memory address
    {2'd2, 16'h8021, 8'h00, 8'h01},  // R2 top bit only
    {2'd0, 16'h0022, 8'h0F, 8'h00},  // R4 dir = 0x0F
    {2'd1, 16'h0022, 8'h00, 8'h0F},  // R4 read back dir
    {2'd0, 16'h0021, 8'hA5, 8'h00},  // R7 drive value
    {2'd1, 16'h0021, 8'h00, 8'hA5},  // R7 read back
    {2'd0, 16'h0221, 8'h3C, 8'h00},  // R2 aliased memory write
    {2'd1, 16'h0021, 8'h00, 8'hA5},  // R2 drive value unchanged
    {2'd1, 16'h0023, 8'h00, 8'h00},  // R8 unmapped offset
    {2'd1, 16'h0121, 8'h00, 8'h00},  // R8 offset differs in bit 8
    {2'd1, 16'h1022, 8'h00, 8'h00},  // R8 memory read gives zero
    {2'd1, 16'h0000, 8'h00, 8'h00}   // R8 offset zero
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    logic [7:0] shadow;
    repeat (3) @(negedge clk);
    // R3 reset state
    check("R3 pin_oe", pin_oe, 8'h00);
    check("R3 pin_out", pin_out, 8'h00);
    rst_n = 1'b1;
    bus_read(16'h0022, rd); check("R3 dir", rd, 8'h00);
    bus_read(16'h0021, rd); check("R3 drv", rd, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [15:0] a;
      logic [7:0]  d, e;
      {op, a, d, e} = VEC[i];
      if (op == 2'd0) bus_write(a, d);
      else if (op == 2'd1) begin
        bus_read(a, rd);
        check($sformatf("vector %0d R7/R8/R4", i), rd, e);
      end else begin
        @(negedge clk);
        bus_addr = a;
        #1 check($sformatf("vector %0d R1/R2 mem_cs", i), {7'd0, mem_cs}, e);
      end
    end

    // R4, R6: dir 0x0F, drive 0xA5
    @(negedge clk);
    check("R4 pin_oe", pin_oe, 8'h0F);
    check("R6 pin_out", pin_out, 8'h05);

    // R7 read-modify-write set, clear, toggle
    shadow = 8'hA5;
    bus_read(16'h0021, rd); bus_write(16'h0021, rd | 8'h42);  shadow = shadow | 8'h42;
    bus_read(16'h0021, rd); check("R7 set", rd, shadow);
    bus_read(16'h0021, rd); bus_write(16'h0021, rd & ~8'h81); shadow = shadow & ~8'h81;
    bus_read(16'h0021, rd); check("R7 clear", rd, shadow);
    bus_read(16'h0021, rd); bus_write(16'h0021, rd ^ 8'h0F);  shadow = shadow ^ 8'h0F;
    bus_read(16'h0021, rd); check("R7 toggle", rd, shadow);
    @(negedge clk);
    check("R6 pin_out after rmw", pin_out, shadow & 8'h0F);

    // R4 all outputs, R6 full drive
    bus_write(16'h0022, 8'hFF);
    @(negedge clk);
    check("R4 pin_oe all", pin_oe, 8'hFF);
    check("R6 pin_out all", pin_out, shadow);

    // R5 two-edge latency
    @(negedge clk);
    pin_in = 8'h96;
    @(negedge clk);
    bus_addr = 16'h0020; bus_re = 1'b1;
    #1 check("R5 after one edge", bus_rdata, 8'h00);
    @(negedge clk);
    #1 check("R5 after two edges", bus_rdata, 8'h96);
    bus_re = 1'b0;

    // R9 write to pin-state register ignored
    bus_write(16'h0020, 8'h5A);
    bus_read(16'h0020, rd); check("R9 pins", rd, 8'h96);
    bus_read(16'h0021, rd); check("R9 drv", rd, shadow);
    bus_read(16'h0022, rd); check("R9 dir", rd, 8'hFF);

    // R8 read enable low
    @(negedge clk);
    bus_addr = 16'h0021; bus_re = 1'b0;
    #1 check("R8 re low", bus_rdata, 8'h00);

    // R3 reset again clears registers
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R3 re-reset oe", pin_oe, 8'h00);
    check("R3 re-reset out", pin_out, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule